// File: doc/BRIEF.md
# Multi-Channel DMA Interrupt Aggregator

This block is the global register slice of a multi-channel DMA engine. Each channel raises a one-cycle completion pulse. The block latches every pulse into a sticky status bit. Software clears status bits by writing ones to them. An enable mask decides which latched events reach the single interrupt line. A read-only view returns the status bits that are also enabled, so a handler can find the channels that need service with one read. The block also holds a one-bit addressing-mode flag.

The block decodes the per-channel register windows as well. Channels are grouped in pairs. The even channel of a pair receives and the odd channel transmits. Each pair owns a 0x40-byte window. The receive registers start at the base of that window and the transmit registers start 0x18 bytes into it. For any address on the register bus, the block reports whether the address names a real channel register, which channel it names (one-hot), and the register offset relative to that channel's base. The channel register files then need only compare this small offset.

Top module: `dma_irq_agg`

## Requirements
- R1: After reset the status, enable and addressing-mode registers read 0, and `irq` is low.
- R2: A pulse on `done_evt[n]` sets status bit n, which stays set until software clears it. Status is read at address 0x080000.
- R3: A write to address 0x080000 clears every status bit whose `wdata` bit is 1 and leaves the other bits unchanged. Writing all ones clears all bits.
- R4: If a completion pulse on bit n arrives in the same cycle as a write of 1 to status bit n, bit n ends up set.
- R5: Address 0x080004 reads as status AND enable. A write to it changes nothing.
- R6: `irq` is high exactly while at least one bit is both set in status and enabled.
- R7: The enable register at address 0x080008 holds the low NCH bits of the last value written to it, and reads back that value.
- R8: A write to address 0x34 loads `wdata[0]` into the addressing-mode flag. The value 1 selects 32-bit addressing. The flag drives `addr32_mode` and reads back at 0x34 in bit 0.
- R9: Address 0x40*k + o with k < NCH/2 names receive channel 2k when o is 0x00, 0x04, 0x0C, 0x10, 0x14 or 0x30. It names transmit channel 2k+1 when o is 0x18, 0x1C, 0x24 or 0x2C. In either case `ch_hit`=1, `ch_sel` has only bit (channel) set, and `ch_off` is o minus the channel's base (0 for receive, 0x18 for transmit).
- R10: Any other address, including any address at or above 0x40*NCH/2, gives `ch_hit`=0 and `ch_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the global registers |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data of the global registers (combinational) |
| done_evt | input | NCH | One-cycle completion pulse per channel |
| irq | output | 1 | Aggregated interrupt |
| addr32_mode | output | 1 | Addressing-mode flag, 1 selects 32-bit addressing |
| ch_hit | output | 1 | Address names a channel register |
| ch_sel | output | NCH | One-hot channel selected by the address |
| ch_off | output | 6 | Register offset relative to the selected channel's base |

## Verification
The bench targets the cycle in which a completion pulse and a clear of the same bit coincide. A design in which the clear takes priority would lose that event, and the bit would read 0. It also writes zeros and all ones to the status register, and writes to the read-only pending view. A design that ignores the write mask would clear unrelated bits, and a design that stores pending writes would change the readback. On the decode side, it sweeps every instance with every legal offset and with near-miss offsets: 0x08, the transmit-relative 0x08 at 0x20, the addressing register at 0x34, and the first address past the last pair. A design with a wrong 0x18 shift, a wrong even/odd assignment or a missing range check then reports a hit on the wrong channel.

// File: rtl/dma_irq_agg.sv
module dma_irq_agg #(
  parameter int NCH = 8,
  parameter int AW  = 20,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic [NCH-1:0] done_evt,
  output logic          irq,
  output logic          addr32_mode,
  output logic          ch_hit,
  output logic [NCH-1:0] ch_sel,
  output logic [5:0]    ch_off
);
  localparam int NPAIR = NCH / 2;
  localparam int IW    = AW - 6;
  localparam logic [AW-1:0] A_STS  = AW'('h80000);
  localparam logic [AW-1:0] A_PEND = AW'('h80004);
  localparam logic [AW-1:0] A_ENA  = AW'('h80008);
  localparam logic [AW-1:0] A_MODE = AW'('h34);

  logic [NCH-1:0] status_q, enable_q, pend;
  logic           mode_q;

  wire sts_wr  = wr_en && (addr == A_STS);
  wire ena_wr  = wr_en && (addr == A_ENA);
  wire mode_wr = wr_en && (addr == A_MODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      enable_q <= '0;
      mode_q   <= 1'b0;
    end else begin
      status_q <= (status_q & ~(sts_wr ? wdata[NCH-1:0] : '0)) | done_evt;
      if (ena_wr)  enable_q <= wdata[NCH-1:0];
      if (mode_wr) mode_q   <= wdata[0];
    end
  end

  assign pend        = status_q & enable_q;
  assign irq         = |pend;
  assign addr32_mode = mode_q;

  always_comb begin
    rdata = '0;
    case (addr)
      A_STS:   rdata[NCH-1:0] = status_q;
      A_PEND:  rdata[NCH-1:0] = pend;
      A_ENA:   rdata[NCH-1:0] = enable_q;
      A_MODE:  rdata[0]       = mode_q;
      default: rdata = '0;
    endcase
  end

  logic [5:0]  win;
  logic [IW-1:0] inst;
  logic        in_range, rx_ok, tx_ok;
  logic [IW:0] chan_num;

  assign win      = addr[5:0];
  assign inst     = addr[AW-1:6];
  assign in_range = int'(inst) < NPAIR;

  always_comb begin
    rx_ok = 1'b0;
    tx_ok = 1'b0;
    case (win)
      6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h30: rx_ok = 1'b1;
      6'h18, 6'h1C, 6'h24, 6'h2C:               tx_ok = 1'b1;
      default: ;
    endcase
  end

  assign chan_num = {inst, tx_ok};
  assign ch_hit   = in_range && (rx_ok || tx_ok);
  assign ch_sel   = ch_hit ? ({{(NCH-1){1'b0}}, 1'b1} << chan_num) : '0;
  assign ch_off   = tx_ok ? win - 6'h18 : win;
endmodule

// File: rtl/dma_irq_agg_chk.sv
module dma_irq_agg_chk #(
  parameter int NCH = 8,
  parameter int AW  = 20,
  parameter int DW  = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic [DW-1:0] wdata,
  input logic [NCH-1:0] done_evt,
  input logic          irq,
  input logic          ch_hit,
  input logic [NCH-1:0] ch_sel,
  input logic [NCH-1:0] status_q,
  input logic [NCH-1:0] enable_q
);
  localparam logic [AW-1:0] S_ADDR = AW'('h80000);
  localparam logic [AW-1:0] E_ADDR = AW'('h80008);

  assert_evt_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_evt) |=> ((status_q & $past(done_evt)) == $past(done_evt)));

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == S_ADDR && done_evt == '0) |=> ((status_q & $past(wdata[NCH-1:0])) == '0));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q == '0 || enable_q == '0) |-> !irq);

  assert_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == E_ADDR) |=> (enable_q == $past(wdata[NCH-1:0])));

  assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ch_hit |-> ($countones(ch_sel) == 1));

  assert_miss_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ch_hit |-> (ch_sel == '0));
endmodule

bind dma_irq_agg dma_irq_agg_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_dma_irq_agg.sv
`timescale 1ns/1ps
module sim_dma_irq_agg;
  localparam int NCH = 8;
  localparam int AW  = 20;
  localparam int DW  = 32;
  localparam logic [AW-1:0] STS  = 20'h80000;
  localparam logic [AW-1:0] PEND = 20'h80004;
  localparam logic [AW-1:0] ENA  = 20'h80008;
  localparam logic [AW-1:0] MODE = 20'h00034;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] addr = '0;
  logic wr_en = 0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [NCH-1:0] done_evt = '0;
  logic irq, addr32_mode, ch_hit;
  logic [NCH-1:0] ch_sel;
  logic [5:0] ch_off;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  dma_irq_agg #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .done_evt(done_evt), .irq(irq), .addr32_mode(addr32_mode),
    .ch_hit(ch_hit), .ch_sel(ch_sel), .ch_off(ch_off));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NCH-1:0] ev);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1; done_evt = ev;
    @(negedge clk);
    wr_en = 0; done_evt = '0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse(input logic [NCH-1:0] ev);
    @(negedge clk);
    done_evt = ev;
    @(negedge clk);
    done_evt = '0;
  endtask

  task automatic t_reset;
    logic [DW-1:0] d;
    rd(STS, d);  chk("R1 status", d, 0);
    rd(ENA, d);  chk("R1 enable", d, 0);
    rd(MODE, d); chk("R1 mode", d, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_sticky;
    logic [DW-1:0] d;
    pulse(8'h08);
    pulse(8'h20);
    repeat (5) @(negedge clk);
    rd(STS, d); chk("R2 sticky status", d, 32'h28);
    chk("R6 irq masked", {31'b0, irq}, 0);
  endtask

  task automatic t_enable;
    logic [DW-1:0] d;
    wr(ENA, 32'h0000_0108, '0);
    rd(ENA, d);  chk("R7 enable readback", d, 32'h08);
    rd(PEND, d); chk("R5 pending", d, 32'h08);
    chk("R6 irq high", {31'b0, irq}, 1);
    wr(PEND, 32'hFFFF_FFFF, '0);
    rd(PEND, d); chk("R5 pending write ignored", d, 32'h08);
    rd(STS, d);  chk("R5 status after pending write", d, 32'h28);
  endtask

  task automatic t_w1c;
    logic [DW-1:0] d;
    wr(STS, 32'h08, '0);
    rd(STS, d); chk("R3 partial clear", d, 32'h20);
    chk("R6 irq low after clear", {31'b0, irq}, 0);
    wr(STS, 32'h0, '0);
    rd(STS, d); chk("R3 zero write keeps", d, 32'h20);
    wr(STS, 32'hFFFF_FFFF, '0);
    rd(STS, d); chk("R3 clear all", d, 0);
  endtask

  task automatic t_race;
    logic [DW-1:0] d;
    pulse(8'h10);
    wr(STS, 32'h12, 8'h02);
    rd(STS, d); chk("R4 event beats clear", d, 32'h02);
    wr(ENA, 32'h02, '0);
    chk("R6 irq from raced bit", {31'b0, irq}, 1);
    wr(STS, 32'hFF, '0);
    wr(ENA, 32'h0, '0);
  endtask

  task automatic t_mode;
    logic [DW-1:0] d;
    wr(MODE, 32'h1, '0);
    rd(MODE, d); chk("R8 mode readback", d, 1);
    chk("R8 addr32_mode", {31'b0, addr32_mode}, 1);
    wr(MODE, 32'h0, '0);
    chk("R8 addr32_mode off", {31'b0, addr32_mode}, 0);
  endtask

  task automatic probe(input logic [AW-1:0] a, input logic hit, input logic [NCH-1:0] sel,
                       input logic [5:0] off, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk({tag, " hit"}, {31'b0, ch_hit}, {31'b0, hit});
    chk({tag, " sel"}, {24'b0, ch_sel}, {24'b0, sel});
    if (hit) chk({tag, " off"}, {26'b0, ch_off}, {26'b0, off});
  endtask

  task automatic t_decode;
    logic [5:0] rx_offs [6] = '{6'h00, 6'h04, 6'h0C, 6'h10, 6'h14, 6'h30};
    logic [5:0] tx_offs [4] = '{6'h00, 6'h04, 6'h0C, 6'h14};
    for (int k = 0; k < NCH/2; k++) begin
      for (int i = 0; i < 6; i++)
        probe(AW'(k*64) + AW'(rx_offs[i]), 1, NCH'(1) << (2*k), rx_offs[i], "R9 rx");
      for (int i = 0; i < 4; i++)
        probe(AW'(k*64 + 24) + AW'(tx_offs[i]), 1, NCH'(1) << (2*k+1), tx_offs[i], "R9 tx");
      probe(AW'(k*64 + 8),  0, '0, 0, "R10 gap 08");
      probe(AW'(k*64 + 32), 0, '0, 0, "R10 gap 20");
      probe(AW'(k*64 + 52), 0, '0, 0, "R10 gap 34");
    end
    probe(AW'(64*NCH/2), 0, '0, 0, "R10 out of range");
    probe(STS, 0, '0, 0, "R10 global reg");
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_sticky();
    t_enable();
    t_w1c();
    t_race();
    t_mode();
    t_decode();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule